// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the per-channel address and count state of a four-channel DMA controller. The host reaches it through byte-wide I/O accesses. Each channel has a 16-bit base address and a 16-bit base count. Both are loaded one byte at a time. A single byte-pointer flip-flop, shared by every channel, decides whether an access reaches the low or the high half. Completing the high half of either register restarts the channel. The working address is reloaded from the base address, and the transferred count returns to zero.

The data mover reports progress as a channel index and a new transferred count. The block clamps that value to the size of the programmed transfer. Host reads do not return stored registers. An address read returns the live address: the working address moved by the transferred count, upward or downward according to a per-channel direction input. A count read returns what remains of the transfer.

A `SHIFT` parameter selects the byte-wide variant (0) or the word-wide variant (1). In the word-wide variant, register ports sit two offsets apart, working values are kept in byte units (register value shifted left by one), and readback is shifted right by one before the byte is chosen.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every base register, working address, transferred count and the byte pointer are zero, so every register byte reads back as 0x00.
- R2: The register index is the port offset shifted right by `SHIFT`. Index bit 0 selects address (0) or count (1), and the index bits above it select the channel. An access changes only the selected channel's registers.
- R3: The byte pointer toggles on every access (read or write) to any channel. When it is 0 the access uses bits [7:0]; when it is 1 the access uses bits [15:8].
- R4: A low-half write replaces only bits [7:0] of the selected base register, and a high-half write replaces only bits [15:8].
- R5: A high-half write to either register of a channel sets that channel's working address to (new base address << SHIFT) and clears its transferred count. A low-half write leaves both unchanged.
- R6: An address read returns a byte of (working address + transferred count), or of (working address - transferred count) when `chan_down` for that channel is 1. The value is taken modulo 2^32 and shifted right by SHIFT before the byte is picked.
- R7: A count read returns a byte of ((base count << SHIFT) - transferred count), modulo 2^32, shifted right by SHIFT before the byte is picked.
- R8: When `prog_vld` is 1, the transferred count of channel `prog_ch` becomes min(`prog_cnt`, (base count + 1) << SHIFT). The limit uses the base count as it stood before any write in the same cycle.
- R9: If a high-half write and a progress report reach the same channel in one cycle, the reload wins and the count is zero. A progress report to another channel in that cycle still takes effect.
- R10: With SHIFT = 1, offset bit 0 is ignored, and R5 to R8 hold with the word scaling, so reads return byte-unit values divided by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Host access to a channel register this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_off | input | CH_W+1+SHIFT | Port offset of the access |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid combinationally during a read access |
| chan_down | input | NUM_CH | Per-channel direction, 1 = address decrements |
| prog_vld | input | 1 | Progress report valid |
| prog_ch | input | CH_W | Channel of the progress report |
| prog_cnt | input | REG_W+SHIFT+1 | New transferred count in byte units |

## Verification
The bench drives the byte-wide and the word-wide variant side by side with the same operations, and compares every read byte against a behavioural model. Full 16-bit writes, followed by readback on every channel, show that channel decode and the byte halves are kept apart. Progress reports on up-counting and down-counting channels show the sign of the address offset. Reports above, at and below the clamp limit show the saturation boundary. Mixed sequences show how the shared pointer and reload ordering interact: a lone low write followed by a read on another channel, and a high write that lands in the same cycle as a progress report on the same channel or on a different one.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  // Replace one byte half of a base register.
  function automatic logic [REG_W-1:0] merge_byte(input logic [REG_W-1:0] old_v,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic hi);
    return hi ? {b, old_v[BYTE_W-1:0]} : {old_v[REG_W-1:BYTE_W], b};
  endfunction

  // Live address seen by the host.
  function automatic logic [31:0] addr_view(input logic [31:0] cur,
                                            input logic [31:0] xfer,
                                            input logic down);
    return down ? (cur - xfer) : (cur + xfer);
  endfunction

  // Remaining count seen by the host.
  function automatic logic [31:0] remain_view(input logic [31:0] base,
                                              input logic [31:0] xfer,
                                              input int sh);
    return (base << sh) - xfer;
  endfunction

  // Largest transferred count a channel may hold.
  function automatic logic [31:0] xfer_limit(input logic [31:0] base, input int sh);
    return (base + 32'd1) << sh;
  endfunction

  function automatic logic [31:0] clamp_xfer(input logic [31:0] req,
                                             input logic [31:0] base,
                                             input int sh);
    logic [31:0] lim;
    lim = xfer_limit(base, sh);
    return (req > lim) ? lim : req;
  endfunction

  // Scale a readback value back to register units and pick a byte.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [31:0] val,
                                                  input int sh,
                                                  input logic hi);
    return BYTE_W'(val >> (sh + (hi ? BYTE_W : 0)));
  endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int OFF_W = CH_W + 1 + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [OFF_W-1:0]  io_off,
  output logic [CH_W-1:0]   acc_ch,
  output reg_sel_e          acc_reg,
  output logic              byte_hi,
  output logic [NUM_CH-1:0] wr_en
);

  logic [CH_W:0] reg_idx;
  logic          ptr_q;

  assign reg_idx = io_off[OFF_W-1:SHIFT];
  assign acc_ch  = reg_idx[CH_W:1];
  assign acc_reg = reg_sel_e'(reg_idx[0]);
  assign byte_hi = ptr_q;

  generate
    if (SHIFT > 0) begin : g_word_lsb
      logic unused_off_lsb;
      assign unused_off_lsb = ^io_off[SHIFT-1:0];
    end
  endgenerate

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_wr_en
      assign wr_en[c] = io_sel && io_wr && (acc_ch == CH_W'(c));
    end
  endgenerate

  // Shared byte pointer: flips on every channel-register access.
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= 1'b0;
    else if (io_sel) ptr_q <= ~ptr_q;
  end

  AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel |=> (byte_hi != $past(byte_hi))); // R3

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel |=> $stable(byte_hi)); // R3

endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int SHIFT  = 0,
  localparam int CUR_W = REG_W + SHIFT,
  localparam int CNT_W = REG_W + SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  reg_sel_e          wr_reg,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              prog_en,
  input  logic [CNT_W-1:0]  prog_cnt,
  input  logic              down,
  output logic [31:0]       addr_rd,
  output logic [31:0]       cnt_rd
);

  logic [REG_W-1:0] base_a, base_c;
  logic [REG_W-1:0] nxt_base_a, nxt_base_c;
  logic [CUR_W-1:0] cur_a;
  logic [CNT_W-1:0] xfer;
  logic             reload;

  assign nxt_base_a = (wr_en && wr_reg == SEL_ADDR) ? merge_byte(base_a, wr_byte, wr_hi) : base_a;
  assign nxt_base_c = (wr_en && wr_reg == SEL_CNT)  ? merge_byte(base_c, wr_byte, wr_hi) : base_c;
  assign reload     = wr_en && wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0;
      base_c <= '0;
      cur_a  <= '0;
      xfer   <= '0;
    end else begin
      base_a <= nxt_base_a;
      base_c <= nxt_base_c;
      if (reload) begin
        cur_a <= CUR_W'(32'(nxt_base_a) << SHIFT);
        xfer  <= '0;
      end else if (prog_en) begin
        xfer <= CNT_W'(clamp_xfer(32'(prog_cnt), 32'(base_c), SHIFT));
      end
    end
  end

  assign addr_rd = addr_view(32'(cur_a), 32'(xfer), down);
  assign cnt_rd  = remain_view(32'(base_c), 32'(xfer), SHIFT);

  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (xfer == '0)); // R5

  AST_LOW_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi && !prog_en) |=> ($stable(cur_a) && $stable(xfer))); // R5

  AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> ((base_a[REG_W-1:BYTE_W] == $past(base_a[REG_W-1:BYTE_W])) &&
                           (base_c[REG_W-1:BYTE_W] == $past(base_c[REG_W-1:BYTE_W])))); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !reload) |=> (32'(xfer) <= xfer_limit(32'($past(base_c)), SHIFT))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !prog_en) |=> ($stable(base_a) && $stable(base_c) &&
                              $stable(cur_a) && $stable(xfer))); // R2

endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0][31:0] addr_rd,
  input  logic [NUM_CH-1:0][31:0] cnt_rd,
  input  logic [CH_W-1:0]         acc_ch,
  input  reg_sel_e                acc_reg,
  input  logic                    byte_hi,
  output logic [BYTE_W-1:0]       rdata
);

  logic [31:0] sel_val;

  always_comb begin
    sel_val = (acc_reg == SEL_CNT) ? cnt_rd[acc_ch] : addr_rd[acc_ch];
    rdata   = pick_byte(sel_val, SHIFT, byte_hi);
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int OFF_W = CH_W + 1 + SHIFT,
  localparam int CNT_W = REG_W + SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic [OFF_W-1:0]  io_off,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [NUM_CH-1:0] chan_down,
  input  logic              prog_vld,
  input  logic [CH_W-1:0]   prog_ch,
  input  logic [CNT_W-1:0]  prog_cnt
);

  logic [CH_W-1:0]         acc_ch;
  reg_sel_e                acc_reg;
  logic                    byte_hi;
  logic [NUM_CH-1:0]       wr_en;
  logic [NUM_CH-1:0]       prog_en;
  logic [NUM_CH-1:0][31:0] addr_rd;
  logic [NUM_CH-1:0][31:0] cnt_rd;

  dma_port_decode #(.NUM_CH(NUM_CH), .SHIFT(SHIFT)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_sel  (io_sel),
    .io_wr   (io_wr),
    .io_off  (io_off),
    .acc_ch  (acc_ch),
    .acc_reg (acc_reg),
    .byte_hi (byte_hi),
    .wr_en   (wr_en)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
      assign prog_en[c] = prog_vld && (prog_ch == CH_W'(c));

      dma_chan_slot #(.SHIFT(SHIFT)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en[c]),
        .wr_hi    (byte_hi),
        .wr_reg   (acc_reg),
        .wr_byte  (io_wdata),
        .prog_en  (prog_en[c]),
        .prog_cnt (prog_cnt),
        .down     (chan_down[c]),
        .addr_rd  (addr_rd[c]),
        .cnt_rd   (cnt_rd[c])
      );
    end
  endgenerate

  dma_read_mux #(.NUM_CH(NUM_CH), .SHIFT(SHIFT)) u_rmux (
    .addr_rd (addr_rd),
    .cnt_rd  (cnt_rd),
    .acc_ch  (acc_ch),
    .acc_reg (acc_reg),
    .byte_hi (byte_hi),
    .rdata   (io_rdata)
  );

endmodule

// File: tb/dma_chan_regs_tb_top.sv
module dma_chan_regs_tb_top;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_sel, io_wr;
  logic [2:0]  io_off0;
  logic [3:0]  io_off1;
  logic [7:0]  io_wdata, rdata0, rdata1;
  logic [3:0]  chan_down;
  logic        prog_vld;
  logic [1:0]  prog_ch;
  logic [16:0] prog_cnt0;
  logic [17:0] prog_cnt1;

  always #(CLK_NS/2) clk = ~clk;

  dma_chan_regs #(.NUM_CH(4), .SHIFT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_off(io_off0),
    .io_wdata(io_wdata), .io_rdata(rdata0), .chan_down(chan_down),
    .prog_vld(prog_vld), .prog_ch(prog_ch), .prog_cnt(prog_cnt0)
  );

  dma_chan_regs #(.NUM_CH(4), .SHIFT(1)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_off(io_off1),
    .io_wdata(io_wdata), .io_rdata(rdata1), .chan_down(chan_down),
    .prog_vld(prog_vld), .prog_ch(prog_ch), .prog_cnt(prog_cnt1)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit junk  = 1'b0;

  logic [31:0] m_ba [2][4];
  logic [31:0] m_bc [2][4];
  logic [31:0] m_ca [2][4];
  logic [31:0] m_xc [2][4];
  bit          m_ff [2];

  function automatic logic [7:0] mdl_read(int v, int ch, int rg);
    logic [31:0] val;
    if (rg != 0)          val = (m_bc[v][ch] << v) - m_xc[v][ch];
    else if (chan_down[ch]) val = m_ca[v][ch] - m_xc[v][ch];
    else                  val = m_ca[v][ch] + m_xc[v][ch];
    val = val >> (v + (m_ff[v] ? 8 : 0));
    return val[7:0];
  endfunction

  task automatic check(int v, logic [7:0] got, logic [7:0] exp, string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s%s: got %h expected %h", req, (v != 0) ? "/R10 word variant" : "", got, exp);
    end
  endtask

  task automatic step(bit sel, bit wr, int ch, int rg, logic [7:0] d,
                      bit pv, int pch, int pcnt, string req);
    logic [31:0] lim, pc;
    @(negedge clk);
    io_sel    = sel;
    io_wr     = wr;
    io_off0   = 3'(ch*2 + rg);
    junk      = ~junk;
    io_off1   = {3'(ch*2 + rg), junk};
    io_wdata  = d;
    prog_vld  = pv;
    prog_ch   = 2'(pch);
    prog_cnt0 = 17'(pcnt);
    prog_cnt1 = 18'(pcnt);
    #1;
    if (sel && !wr) begin
      check(0, rdata0, mdl_read(0, ch, rg), req);
      check(1, rdata1, mdl_read(1, ch, rg), req);
    end
    @(posedge clk);
    #1;
    pc = 32'(pcnt);
    for (int v = 0; v < 2; v++) begin
      if (pv) begin
        lim = (m_bc[v][pch] + 32'd1) << v;
        m_xc[v][pch] = (pc > lim) ? lim : pc;
      end
      if (sel) begin
        if (wr) begin
          if (rg != 0)
            m_bc[v][ch] = m_ff[v] ? ((m_bc[v][ch] & 32'h00ff) | (32'(d) << 8))
                                  : ((m_bc[v][ch] & 32'hff00) | 32'(d));
          else
            m_ba[v][ch] = m_ff[v] ? ((m_ba[v][ch] & 32'h00ff) | (32'(d) << 8))
                                  : ((m_ba[v][ch] & 32'hff00) | 32'(d));
          if (m_ff[v]) begin
            m_ca[v][ch] = m_ba[v][ch] << v;
            m_xc[v][ch] = 32'd0;
          end
        end
        m_ff[v] = !m_ff[v];
      end
    end
  endtask

  task automatic wr16(int ch, int rg, logic [15:0] val, string req);
    step(1, 1, ch, rg, val[7:0], 0, 0, 0, req);
    step(1, 1, ch, rg, val[15:8], 0, 0, 0, req);
  endtask

  task automatic rd16(int ch, int rg, string req);
    step(1, 0, ch, rg, 8'h00, 0, 0, 0, req);
    step(1, 0, ch, rg, 8'h00, 0, 0, 0, req);
  endtask

  task automatic prog(int ch, int cnt, string req);
    step(0, 0, 0, 0, 8'h00, 1, ch, cnt, req);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_sel = 1'b0; io_wr = 1'b0; io_off0 = '0; io_off1 = '0;
    io_wdata = '0; chan_down = '0; prog_vld = 1'b0; prog_ch = '0;
    prog_cnt0 = '0; prog_cnt1 = '0;
    for (int v = 0; v < 2; v++) begin
      m_ff[v] = 1'b0;
      for (int c = 0; c < 4; c++) begin
        m_ba[v][c] = '0; m_bc[v][c] = '0; m_ca[v][c] = '0; m_xc[v][c] = '0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Reset state of every register byte
    for (int c = 0; c < 4; c++) begin
      rd16(c, 0, "R1");
      rd16(c, 1, "R1");
    end

    // Full programming of all channels, then readback per channel
    for (int c = 0; c < 4; c++) begin
      wr16(c, 0, 16'h1234 + 16'(c) * 16'h1111, "R4");
      wr16(c, 1, 16'h0020 + 16'(c), "R4");
    end
    for (int c = 0; c < 4; c++) begin
      rd16(c, 0, "R2");
      rd16(c, 1, "R7");
    end

    // Progress on an up-counting and a down-counting channel
    chan_down = 4'b0100;
    prog(1, 5, "R8");
    prog(2, 7, "R8");
    rd16(1, 0, "R6");
    rd16(2, 0, "R6");
    rd16(1, 1, "R7");
    rd16(2, 1, "R7");

    // Clamp above, then exactly at, the limit
    prog(3, 200, "R8");
    rd16(3, 1, "R8");
    rd16(3, 0, "R8");
    prog(3, 'h24, "R8");
    rd16(3, 1, "R8");
    prog(3, 'h10, "R8");
    rd16(3, 1, "R8");

    // Lone low write keeps progress; pointer then steers a read to the high byte
    step(1, 1, 1, 1, 8'h40, 0, 0, 0, "R5");
    step(1, 0, 1, 0, 8'h00, 0, 0, 0, "R3");
    rd16(1, 0, "R5");
    rd16(1, 1, "R4");

    // Direction flip on a channel with progress
    chan_down = 4'b0110;
    rd16(1, 0, "R6");

    // Reload and progress on the same channel in one cycle
    step(1, 1, 0, 0, 8'h99, 0, 0, 0, "R4");
    step(1, 1, 0, 0, 8'hAB, 1, 0, 3, "R9");
    rd16(0, 0, "R9");
    rd16(0, 1, "R9");

    // Reload on one channel while another reports progress
    step(1, 1, 3, 1, 8'h10, 0, 0, 0, "R4");
    step(1, 1, 3, 1, 8'h00, 1, 2, 9, "R9");
    rd16(2, 0, "R9");
    rd16(3, 1, "R9");
    rd16(3, 0, "R5");

    // Shared pointer across writes and reads on different channels
    step(1, 1, 0, 1, 8'h55, 0, 0, 0, "R3");
    step(1, 0, 2, 1, 8'h00, 0, 0, 0, "R3");
    wr16(1, 0, 16'h0177, "R3");
    rd16(1, 0, "R3");
    rd16(0, 1, "R3");

    step(0, 0, 0, 0, 8'h00, 0, 0, 0, "idle");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule